// File: doc/BRIEF.md
# Configuration-Store Command Register Controller

This block sits on the device side of a byte-wide configuration register window and fronts a small nonvolatile configuration store of 16-bit words. A host loads a byte offset into two address registers and, for a store update, a 16-bit value into two data registers. It then writes a command code into a control register and polls a completion flag in that register until it reads 1. The store itself is modelled as an on-chip array that reset fills with a fixed pattern, and a store update is given a parameterised latency so that host polling behaves as it would against a slow serial part.

Updates are gated by an enable latch that the host sets and clears with dedicated commands. An image rewrite therefore opens with the enable command, streams one write per word, and closes with the disable command. A write issued while the latch is clear still completes and raises the flag, but it leaves the store as it was. Every command captures the address and data registers in the cycle it is accepted. Later host writes to those registers do not affect a command that is already running.

Top module: `cfgprom_regctl`

## Requirements
- R1: After reset the completion flag is 0, the last-command field is 0, all four address and data registers read 0, updates are disabled, and store word i holds {~i[7:0], i[7:0]} (word 5 = 16'hFA05).
- R2: Register offsets are fixed. The control register is at 0x36 and reads {4'b0, done, lastCmd[2:0]}, with done at bit 3. Data low is at 0x38, data high at 0x3A, address low at 0x3C and address high at 0x3E. The data and address registers read back what the host last wrote. Any other offset reads 0.
- R3: Read command (code 2) takes the word index from bits 8:1 of the 16-bit byte offset {addrHi, addrLo}; bit 0 and bits 15:9 are ignored. The selected word lands with its low byte at 0x38 and its high byte at 0x3A. Done reads 1 from the second cycle after the cycle in which the command was written.
- R4: An accepted command clears done in the cycle after its write, and done then stays 0 until that command completes.
- R5: Code 4 enables updates and code 7 disables them. A write command (code 1) issued while updates are enabled holds done at 0 for WR_LAT cycles, then stores the captured data word at the captured index and sets done.
- R6: A write command issued while updates are disabled sets done on the same schedule as a read and leaves the store unchanged.
- R7: A command written while another command is still running is ignored. It changes neither the last-command field, nor done, nor the store.
- R8: If the host writes a data register in the same cycle that a read command loads the data registers, the loaded word wins.
- R9: Code 0 and the unassigned codes 3, 5 and 6 complete like a read but have no other effect. The last-command field still shows the code.
- R10: Host writes to the address or data registers while an update is pending do not change the word that is stored, nor where it is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe for this cycle |
| regAddr | input | 8 | Register byte offset, used for both reads and writes |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read data for the register at regAddr |

## Verification
Two events can land in the same edge. One is a read command's load of the data registers; the other is a host write to one of those same registers. The bench forces this overlap by writing the read command and then, in the very next cycle, writing a marker value to the low data register. It then reads that register back and expects the stored word's low byte, not the marker. A second overlap is a new command arriving while an update is still pending. The bench judges that case by the last-command field and by the cycle in which done rises, and a cycle-accurate reference model compares every register read on every clock.

// File: rtl/cfgprom_pkg.sv
package cfgprom_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int OFS_W  = 8;

  // Register window offsets (host software depends on these).
  localparam logic [OFS_W-1:0] OFS_CTRL = 8'h36;
  localparam logic [OFS_W-1:0] OFS_DLO  = 8'h38;
  localparam logic [OFS_W-1:0] OFS_DHI  = 8'h3A;
  localparam logic [OFS_W-1:0] OFS_ALO  = 8'h3C;
  localparam logic [OFS_W-1:0] OFS_AHI  = 8'h3E;

  // Command codes.
  localparam logic [2:0] CMD_NOP   = 3'd0;
  localparam logic [2:0] CMD_WRITE = 3'd1;
  localparam logic [2:0] CMD_READ  = 3'd2;
  localparam logic [2:0] CMD_WEN   = 3'd4;
  localparam logic [2:0] CMD_WDIS  = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_WAIT
  } ctrlState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic snap;        // capture index and data word
    logic loadRead;    // load data registers from store
    logic commitWrite; // write captured word into store
  } strobe_t;

endpackage

// File: rtl/cfgprom_datapath.sv
module cfgprom_datapath
  import cfgprom_pkg::*;
#(
  parameter int WORDS = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [OFS_W-1:0]    regAddr,
  input  logic [BYTE_W-1:0]   regWrData,
  input  strobe_t             stb,
  input  logic [BYTE_W-1:0]   ctrlStatus,
  output logic                cmdWr,
  output logic [2:0]          cmdCode,
  output logic [BYTE_W-1:0]   regRdData
);

  localparam int IDX_W = $clog2(WORDS);

  logic [BYTE_W-1:0] dataLo, dataHi, addrLo, addrHi;
  logic [IDX_W-1:0]  snapIdx;
  logic [WORD_W-1:0] snapData;
  logic [IDX_W-1:0]  idxNext;
  logic [WORD_W-1:0] storeRd [WORDS];
  logic [WORD_W-1:0] rdWord;

  function automatic logic [WORD_W-1:0] initWord(input int unsigned i);
    logic [BYTE_W-1:0] b;
    b = i[BYTE_W-1:0];
    return {~b, b};
  endfunction

  assign cmdWr   = regWr && (regAddr == OFS_CTRL);
  assign cmdCode = regWrData[2:0];
  assign idxNext = IDX_W'({addrHi, addrLo} >> 1);

  // Host-visible address and data registers; a read load overrides a host write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLo <= '0;
      dataHi <= '0;
      addrLo <= '0;
      addrHi <= '0;
    end else begin
      if (regWr) begin
        case (regAddr)
          OFS_DLO: dataLo <= regWrData;
          OFS_DHI: dataHi <= regWrData;
          OFS_ALO: addrLo <= regWrData;
          OFS_AHI: addrHi <= regWrData;
          default: ;
        endcase
      end
      if (stb.loadRead) begin
        dataLo <= rdWord[BYTE_W-1:0];
        dataHi <= rdWord[WORD_W-1:BYTE_W];
      end
    end
  end

  // Command-time capture of index and data.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapIdx  <= '0;
      snapData <= '0;
    end else if (stb.snap) begin
      snapIdx  <= idxNext;
      snapData <= {dataHi, dataLo};
    end
  end

  // Store array, one register word per entry.
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wordQ <= initWord(w);
      else if (stb.commitWrite && (snapIdx == IDX_W'(w)))
        wordQ <= snapData;
    end
    assign storeRd[w] = wordQ;
  end

  assign rdWord = storeRd[snapIdx];

  always_comb begin
    case (regAddr)
      OFS_CTRL: regRdData = ctrlStatus;
      OFS_DLO:  regRdData = dataLo;
      OFS_DHI:  regRdData = dataHi;
      OFS_ALO:  regRdData = addrLo;
      OFS_AHI:  regRdData = addrHi;
      default:  regRdData = '0;
    endcase
  end

  // R8: a read load lands the addressed word even against a host write.
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadRead |=> ({dataHi, dataLo} == $past(rdWord)));

  // R9: at most one control strobe per cycle.
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

endmodule

// File: rtl/cfgprom_ctrl.sv
module cfgprom_ctrl
  import cfgprom_pkg::*;
#(
  parameter int WR_LAT = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [2:0]        cmdCode,
  output strobe_t           stb,
  output logic [BYTE_W-1:0] ctrlStatus
);

  localparam int CNT_W = $clog2(WR_LAT + 1);

  ctrlState_e       state;
  logic [CNT_W-1:0] cnt;
  logic             doneQ;
  logic             weEn;
  logic [2:0]       lastCmd;
  logic [2:0]       pendCmd;
  logic             accept;

  assign accept = cmdWr && (state == ST_IDLE);

  always_comb begin
    stb.snap        = accept;
    stb.loadRead    = (state == ST_EXEC) && (pendCmd == CMD_READ);
    stb.commitWrite = (state == ST_WAIT) && (cnt == '0);
  end

  assign ctrlStatus = {4'b0000, doneQ, lastCmd};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      doneQ   <= 1'b0;
      weEn    <= 1'b0;
      lastCmd <= CMD_NOP;
      pendCmd <= CMD_NOP;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            doneQ   <= 1'b0;
            lastCmd <= cmdCode;
            pendCmd <= cmdCode;
            if ((cmdCode == CMD_WRITE) && weEn) begin
              state <= ST_WAIT;
              cnt   <= CNT_W'(WR_LAT - 1);
            end else begin
              state <= ST_EXEC;
            end
          end
        end
        ST_EXEC: begin
          if (pendCmd == CMD_WEN)  weEn <= 1'b1;
          if (pendCmd == CMD_WDIS) weEn <= 1'b0;
          doneQ <= 1'b1;
          state <= ST_IDLE;
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            doneQ <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: acceptance clears done in the next cycle.
  a_r4_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !doneQ);

  // R7: a command during a running one leaves the last-command field alone.
  a_r7_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (state != ST_IDLE)) |=> $stable(lastCmd));

  // R5: a store update only commits with updates enabled.
  a_r5_commit_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    stb.commitWrite |-> weEn);

  // R3: done only rises as a command finishes.
  a_r3_done_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(state != ST_IDLE));

  // R6: a write with updates disabled takes the short path.
  a_r6_disabled_short: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (cmdCode == CMD_WRITE) && !weEn) |=> (state == ST_EXEC));

endmodule

// File: rtl/cfgprom_regctl.sv
module cfgprom_regctl
  import cfgprom_pkg::*;
#(
  parameter int WORDS  = 256,
  parameter int WR_LAT = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData
);

  strobe_t           stb;
  logic              cmdWr;
  logic [2:0]        cmdCode;
  logic [BYTE_W-1:0] ctrlStatus;

  cfgprom_ctrl #(.WR_LAT(WR_LAT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWr      (cmdWr),
    .cmdCode    (cmdCode),
    .stb        (stb),
    .ctrlStatus (ctrlStatus)
  );

  cfgprom_datapath #(.WORDS(WORDS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .stb        (stb),
    .ctrlStatus (ctrlStatus),
    .cmdWr      (cmdWr),
    .cmdCode    (cmdCode),
    .regRdData  (regRdData)
  );

endmodule

// File: tb/cfgprom_regctl_bench.sv
`timescale 1ns/1ps
module cfgprom_regctl_bench;

  localparam int WORDS  = 256;
  localparam int WR_LAT = 40;
  localparam int A_CTRL = 'h36, A_DLO = 'h38, A_DHI = 'h3A, A_ALO = 'h3C, A_AHI = 'h3E;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  cfgprom_regctl #(.WORDS(WORDS), .WR_LAT(WR_LAT)) u_cfgprom_regctl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  // ---------------- behavioural reference model ----------------
  int mStore[WORDS];
  int mDlo, mDhi, mAlo, mAhi, mDone, mCmd, mWe;
  int pend, pendEdge, pendCmd, pendStore, snapIdx, snapData, cyc;

  function automatic int pat(int i);
    return (((~i) & 255) << 8) | (i & 255);
  endfunction

  function automatic int modelRead(int a);
    if (a == A_CTRL) return (mDone << 3) | mCmd;
    if (a == A_DLO) return mDlo;
    if (a == A_DHI) return mDhi;
    if (a == A_ALO) return mAlo;
    if (a == A_AHI) return mAhi;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mStore[i] = pat(i);
      mDlo = 0; mDhi = 0; mAlo = 0; mAhi = 0;
      mDone = 0; mCmd = 0; mWe = 0; pend = 0; cyc = 0;
    end else begin
      int busy;
      cyc++;
      busy = pend;
      if (regWr) begin
        if (regAddr == A_DLO) mDlo = regWrData;
        if (regAddr == A_DHI) mDhi = regWrData;
        if (regAddr == A_ALO) mAlo = regWrData;
        if (regAddr == A_AHI) mAhi = regWrData;
      end
      if (pend != 0 && cyc == pendEdge) begin
        if (pendCmd == 2) begin
          mDlo = mStore[snapIdx] & 255;
          mDhi = (mStore[snapIdx] >> 8) & 255;
        end
        if (pendStore != 0) mStore[snapIdx] = snapData;
        if (pendCmd == 4) mWe = 1;
        if (pendCmd == 7) mWe = 0;
        mDone = 1;
        pend = 0;
      end
      if (regWr && regAddr == A_CTRL && busy == 0) begin
        mDone = 0;
        mCmd = regWrData & 7;
        pendCmd = mCmd;
        snapIdx = (((mAhi << 8) | mAlo) >> 1) & (WORDS - 1);
        snapData = (mDhi << 8) | mDlo;
        pendStore = (mCmd == 1 && mWe != 0) ? 1 : 0;
        pendEdge = (pendStore != 0) ? cyc + WR_LAT : cyc + 1;
        pend = 1;
      end
    end
  end

  // R2: every-cycle comparison of the addressed register against the model.
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      compared++;
      if (int'(regRdData) != modelRead(int'(regAddr))) begin
        mismatched++;
        $display("FAIL R2 per-cycle view addr=%02h actual=%02h expected=%02h",
                 regAddr, regRdData, modelRead(int'(regAddr)));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 8'(a); regWrData = 8'(d);
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    regWr = 1'b0; regAddr = 8'(a);
    #1 v = int'(regRdData);
  endtask

  task automatic waitDone(output int lowCycles);
    int v;
    lowCycles = 0;
    for (int k = 0; k < 2000; k++) begin
      rd(A_CTRL, v);
      if ((v & 8) != 0) break;
      lowCycles++;
    end
  endtask

  task automatic setIdx(int idx);
    wr(A_ALO, (idx * 2) & 255);
    wr(A_AHI, (idx * 2) >> 8);
  endtask

  task automatic readWord(int idx, output int w);
    int lo, hi, n;
    setIdx(idx);
    wr(A_CTRL, 2);
    waitDone(n);
    rd(A_DLO, lo);
    rd(A_DHI, hi);
    w = (hi << 8) | lo;
  endtask

  task automatic writeWord(int idx, int w, output int lowCycles);
    setIdx(idx);
    wr(A_DLO, w & 255);
    wr(A_DHI, w >> 8);
    wr(A_CTRL, 1);
    waitDone(lowCycles);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int v, w, n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rd(A_CTRL, v); chk("R1 ctrl after reset", v, 0);
    rd(A_DLO, v);  chk("R1 data low after reset", v, 0);
    rd(A_AHI, v);  chk("R1 addr high after reset", v, 0);
    readWord(5, w); chk("R1 initial word 5", w, 'hFA05);

    // R2: readback and unmapped offsets
    wr(A_ALO, 'h5A); rd(A_ALO, v); chk("R2 addr low readback", v, 'h5A);
    wr(A_DHI, 'hC3); rd(A_DHI, v); chk("R2 data high readback", v, 'hC3);
    rd('h37, v); chk("R2 unmapped offset", v, 0);

    // R3/R4: read timing and index decode (byte 0x1FF -> word 255)
    wr(A_ALO, 'hFF); wr(A_AHI, 'h01); wr(A_CTRL, 2);
    rd(A_CTRL, v); chk("R4 done cleared after command", v & 8, 0);
    rd(A_CTRL, v); chk("R3 done two cycles after command", v, 8 | 2);
    rd(A_DLO, v);  chk("R3 low byte of word 255", v, 'hFF);
    rd(A_DHI, v);  chk("R3 high byte of word 255", v, 'h00);
    wr(A_ALO, 'h14); wr(A_AHI, 'h02); wr(A_CTRL, 2); waitDone(n);
    rd(A_DLO, v);  chk("R3 bit 9 ignored, word 10 low", v, 'h0A);

    // R6: write while disabled
    writeWord(7, 'h1234, n);
    chk("R6 disabled write completes fast", n, 1);
    readWord(7, w); chk("R6 store unchanged", w, pat(7));

    // R5: enable, latency, commit
    wr(A_CTRL, 4); waitDone(n);
    writeWord(7, 'hBEEF, n);
    chk("R5 done low for WR_LAT cycles", n, WR_LAT);
    readWord(7, w); chk("R5 committed word", w, 'hBEEF);

    // R10: register edits during latency do not leak into the pending write
    setIdx(20); wr(A_DLO, 'h11); wr(A_DHI, 'h22); wr(A_CTRL, 1);
    wr(A_DLO, 'h99); wr(A_ALO, 'h00);
    waitDone(n);
    readWord(20, w); chk("R10 captured data and index", w, 'h2211);
    readWord(0, w);  chk("R10 other word untouched", w, pat(0));

    // R7: command during a running write is ignored
    setIdx(30); wr(A_DLO, 'h01); wr(A_DHI, 'h80); wr(A_CTRL, 1);
    wr(A_CTRL, 2);
    waitDone(n);
    chk("R7 write latency not cut short", n, WR_LAT - 1);
    rd(A_CTRL, v); chk("R7 last command kept", v, 8 | 1);

    // R8: same-cycle host write to data low loses to the read load
    setIdx(9); wr(A_CTRL, 2); wr(A_DLO, 'h55);
    rd(A_DLO, v); chk("R8 read load wins", v, 'h09);

    // R9: NOP and unassigned codes
    wr(A_CTRL, 3); rd(A_CTRL, v); rd(A_CTRL, v); chk("R9 code 3 completes", v, 8 | 3);
    wr(A_CTRL, 0); rd(A_CTRL, v); rd(A_CTRL, v); chk("R9 code 0 completes", v, 8);
    writeWord(40, 'h0F0F, n); chk("R9 enable survives unassigned codes", n, WR_LAT);

    // R5: disable stops updates again
    wr(A_CTRL, 7); waitDone(n);
    writeWord(41, 'hAAAA, n);
    readWord(41, w); chk("R5 disable blocks store", w, pat(41));

    @(negedge clk); regWr = 1'b0;
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule